// File: doc/BRIEF.md
# Data-Space Address Generator and Region Decoder

This block sits in the load/store path of an 8-bit microcontroller. Each cycle it takes an addressing mode, a pointer choice, a 6-bit displacement and a 16-bit direct address. From these it forms the effective data address. It keeps the three 16-bit pointers in a small model of the top six working registers. For the pre-decrement and post-increment modes it writes the changed pointer back on the clock edge.

The effective address is decoded against one linear data space. The working registers come first, then the standard I/O window, then the extended I/O window, and then the internal SRAM, whose size is a parameter. The block asserts exactly one region select and gives the byte offset inside that region. An address above the SRAM is flagged as out of range.

The address and decode paths are purely combinational. The only sequential state is the pointer storage. There is no control sequencer: the access is a single-cycle event gated by `acc_en_i`.

Top module: `dsag_top`

## Requirements
- R1: Mode code 0 (direct) drives the effective address equal to `dir_addr_i`, over the full 16-bit range, and leaves all pointers unchanged.
- R2: Mode code 1 (indirect) drives the effective address equal to the selected pointer: select 0 = X (registers 27:26), 1 = Y (29:28), 2 = Z (31:30). Select 3 is illegal in every pointer mode.
- R3: Mode code 2 (displacement) gives the effective address Y or Z plus the unsigned `disp_i` (0..63), wrapping modulo 2^16. With select X or 3, `illegal_o` is high, no region select is high, and no write-back occurs.
- R4: Mode code 3 (pre-decrement) gives the effective address as pointer minus 1, and stores that value into the pointer at the clock edge while `acc_en_i` is high. 0x0000 wraps to 0xFFFF.
- R5: Mode code 4 (post-increment) gives the effective address as the old pointer, and stores pointer plus 1 at the clock edge while `acc_en_i` is high. 0xFFFF wraps to 0x0000.
- R6: Addresses 0x0000-0x001F select the register region (offset = address), 0x0020-0x005F the I/O region (offset = address - 0x20), and 0x0060-0x00FF the extended I/O region (offset = address - 0x60). At most one select is high at any time.
- R7: SRAM spans 0x0100 up to 0x0100 + SRAM_BYTES - 1 (SRAM_BYTES is 1024, 2048 or 4096; the default 2048 gives a top of 0x08FF), with offset = address - 0x100. Any higher address raises `oor_o`, with no select high and an offset of 0.
- R8: Mode code 5 (short I/O) uses `dir_addr_i[5:0]` as an I/O index and forms the address index + 0x20. The upper address bits are ignored, so this mode always lands in the I/O region and never in the extended I/O region.
- R9: Reset clears all pointers to 0. A high `ld_en_i` writes `ld_val_i` into pointer `ld_sel_i` at the clock edge. If a write-back targets the same pointer on the same edge, the write-back wins.
- R10: With `acc_en_i` low, no pointer changes from an access and `wb_en_o` is low, while the address and decode outputs still follow the inputs. Mode codes 6 and 7 are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Access valid; allows pointer write-back |
| mode_i | input | 3 | Addressing mode code |
| ptr_sel_i | input | 2 | Pointer select (0 X, 1 Y, 2 Z) |
| disp_i | input | 6 | Unsigned displacement |
| dir_addr_i | input | 16 | Direct address / short I/O index |
| ld_en_i | input | 1 | Pointer load enable |
| ld_sel_i | input | 2 | Pointer to load |
| ld_val_i | input | 16 | Pointer load value |
| ea_o | output | 16 | Effective address |
| sel_reg_o | output | 1 | Register region select |
| sel_io_o | output | 1 | Standard I/O region select |
| sel_xio_o | output | 1 | Extended I/O region select |
| sel_sram_o | output | 1 | SRAM region select |
| oor_o | output | 1 | Address above SRAM top |
| illegal_o | output | 1 | Illegal mode/select combination |
| offset_o | output | 16 | Offset within selected region |
| wb_en_o | output | 1 | Pointer write-back this edge |
| wb_sel_o | output | 2 | Pointer being written back |
| wb_val_o | output | 16 | Value being written back |
| ptr_x_o | output | 16 | Current X pointer |
| ptr_y_o | output | 16 | Current Y pointer |
| ptr_z_o | output | 16 | Current Z pointer |

## Verification
The hardest cases to reach are the wrap edges of pointer arithmetic and the clash between a load and a write-back on the same edge. Both need a pointer held at 0x0000 or 0xFFFF, or updated by two sources at once. The stimulus first drives the load port to place a pointer at exactly that edge value. It then issues the updating access in the next cycle, or in the same cycle as a load to the same pointer. After that edge it reads the pointer back on its output port.

// File: rtl/dsag_pkg.sv
package dsag_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4,
        AM_SHORTIO = 3'd5
    } amode_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REG,
        RG_IO,
        RG_XIO,
        RG_SRAM
    } region_e;

    localparam int unsigned AW       = 16;
    localparam int unsigned NUM_PTR  = 3;
    localparam logic [1:0]  PTR_X    = 2'd0;
    localparam logic [1:0]  PTR_Y    = 2'd1;
    localparam logic [1:0]  PTR_Z    = 2'd2;
    localparam logic [AW-1:0] IO_BASE   = 16'h0020;
    localparam logic [AW-1:0] XIO_BASE  = 16'h0060;
    localparam logic [AW-1:0] SRAM_BASE = 16'h0100;
endpackage

// File: rtl/dsag_ptr_file.sv
module dsag_ptr_file
    import dsag_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_en,
    input  logic [1:0]             ld_sel,
    input  logic [AW-1:0]          ld_val,
    input  logic                   wb_en,
    input  logic [1:0]             wb_sel,
    input  logic [AW-1:0]          wb_val,
    output logic [NUM_PTR-1:0][AW-1:0] ptrs
);
    // Byte-wide model of the six upper working registers; pointer g is
    // the pair {reg[2g+1], reg[2g]}.
    localparam int unsigned NBYTES = 2 * NUM_PTR;
    logic [NBYTES-1:0][7:0] regs_q;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic hit_wb, hit_ld;
        assign hit_wb = wb_en && (wb_sel == 2'(g));
        assign hit_ld = ld_en && (ld_sel == 2'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[2*g]   <= 8'h00;
                regs_q[2*g+1] <= 8'h00;
            end else if (hit_wb) begin
                regs_q[2*g]   <= wb_val[7:0];
                regs_q[2*g+1] <= wb_val[15:8];
            end else if (hit_ld) begin
                regs_q[2*g]   <= ld_val[7:0];
                regs_q[2*g+1] <= ld_val[15:8];
            end
        end

        assign ptrs[g] = {regs_q[2*g+1], regs_q[2*g]};
    end
endmodule

// File: rtl/dsag_agen.sv
module dsag_agen
    import dsag_pkg::*;
(
    input  logic [2:0]                 mode,
    input  logic [1:0]                 ptr_sel,
    input  logic [5:0]                 disp,
    input  logic [AW-1:0]              dir_addr,
    input  logic [NUM_PTR-1:0][AW-1:0] ptrs,
    output logic [AW-1:0]              ea,
    output logic                       illegal,
    output logic                       upd,
    output logic [AW-1:0]              new_ptr
);
    logic [AW-1:0] base;
    logic          sel_ok;

    always_comb begin
        sel_ok = (ptr_sel != 2'd3);
        base   = sel_ok ? ptrs[ptr_sel] : '0;
    end

    always_comb begin
        ea      = '0;
        illegal = 1'b0;
        upd     = 1'b0;
        new_ptr = base;
        unique case (amode_e'(mode))
            AM_DIRECT: begin
                ea = dir_addr;
            end
            AM_IND: begin
                ea      = base;
                illegal = !sel_ok;
            end
            AM_DISP: begin
                ea      = base + {10'd0, disp};
                illegal = !((ptr_sel == PTR_Y) || (ptr_sel == PTR_Z));
            end
            AM_PREDEC: begin
                new_ptr = base - 16'd1;
                ea      = new_ptr;
                upd     = sel_ok;
                illegal = !sel_ok;
            end
            AM_POSTINC: begin
                ea      = base;
                new_ptr = base + 16'd1;
                upd     = sel_ok;
                illegal = !sel_ok;
            end
            AM_SHORTIO: begin
                ea = IO_BASE + {10'd0, dir_addr[5:0]};
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dsag_decode.sv
module dsag_decode
    import dsag_pkg::*;
#(
    parameter int unsigned SRAM_BYTES = 2048
)(
    input  logic [AW-1:0] ea,
    input  logic          block,
    output region_e       region,
    output logic [AW-1:0] offset,
    output logic          oor
);
    localparam logic [AW:0] SRAM_LAST = (AW+1)'(int'(SRAM_BASE) + SRAM_BYTES - 1);

    always_comb begin
        region = RG_NONE;
        offset = '0;
        oor    = 1'b0;
        if (block) begin
            region = RG_NONE;
        end else if (ea < IO_BASE) begin
            region = RG_REG;
            offset = ea;
        end else if (ea < XIO_BASE) begin
            region = RG_IO;
            offset = ea - IO_BASE;
        end else if (ea < SRAM_BASE) begin
            region = RG_XIO;
            offset = ea - XIO_BASE;
        end else if ({1'b0, ea} <= SRAM_LAST) begin
            region = RG_SRAM;
            offset = ea - SRAM_BASE;
        end else begin
            oor = 1'b1;
        end
    end
endmodule

// File: rtl/dsag_top.sv
module dsag_top
    import dsag_pkg::*;
#(
    parameter int unsigned SRAM_BYTES = 2048
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en_i,
    input  logic [2:0]  mode_i,
    input  logic [1:0]  ptr_sel_i,
    input  logic [5:0]  disp_i,
    input  logic [15:0] dir_addr_i,
    input  logic        ld_en_i,
    input  logic [1:0]  ld_sel_i,
    input  logic [15:0] ld_val_i,
    output logic [15:0] ea_o,
    output logic        sel_reg_o,
    output logic        sel_io_o,
    output logic        sel_xio_o,
    output logic        sel_sram_o,
    output logic        oor_o,
    output logic        illegal_o,
    output logic [15:0] offset_o,
    output logic        wb_en_o,
    output logic [1:0]  wb_sel_o,
    output logic [15:0] wb_val_o,
    output logic [15:0] ptr_x_o,
    output logic [15:0] ptr_y_o,
    output logic [15:0] ptr_z_o
);
    logic [NUM_PTR-1:0][AW-1:0] ptrs;
    logic [AW-1:0] ea, new_ptr;
    logic          illegal, upd;
    region_e       region;

    dsag_agen u_agen (
        .mode    (mode_i),
        .ptr_sel (ptr_sel_i),
        .disp    (disp_i),
        .dir_addr(dir_addr_i),
        .ptrs    (ptrs),
        .ea      (ea),
        .illegal (illegal),
        .upd     (upd),
        .new_ptr (new_ptr)
    );

    dsag_decode #(.SRAM_BYTES(SRAM_BYTES)) u_dec (
        .ea    (ea),
        .block (illegal),
        .region(region),
        .offset(offset_o),
        .oor   (oor_o)
    );

    assign wb_en_o  = acc_en_i && upd && !illegal;
    assign wb_sel_o = ptr_sel_i;
    assign wb_val_o = new_ptr;

    dsag_ptr_file u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_en (ld_en_i),
        .ld_sel(ld_sel_i),
        .ld_val(ld_val_i),
        .wb_en (wb_en_o),
        .wb_sel(wb_sel_o),
        .wb_val(wb_val_o),
        .ptrs  (ptrs)
    );

    assign ea_o       = ea;
    assign illegal_o  = illegal;
    assign sel_reg_o  = (region == RG_REG);
    assign sel_io_o   = (region == RG_IO);
    assign sel_xio_o  = (region == RG_XIO);
    assign sel_sram_o = (region == RG_SRAM);
    assign ptr_x_o    = ptrs[PTR_X];
    assign ptr_y_o    = ptrs[PTR_Y];
    assign ptr_z_o    = ptrs[PTR_Z];

    // R6: region selects never overlap
    p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_reg_o, sel_io_o, sel_xio_o, sel_sram_o}));

    // R7: out of range keeps every select low
    p_oor_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oor_o |-> !(sel_reg_o || sel_io_o || sel_xio_o || sel_sram_o));

    // R3: displacement off X is illegal and never writes back
    p_disp_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == AM_DISP && ptr_sel_i == PTR_X) |-> (illegal_o && !wb_en_o && !sel_reg_o
            && !sel_io_o && !sel_xio_o && !sel_sram_o));

    // R4: pre-decrement stores the address it used
    p_predec_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o && mode_i == AM_PREDEC) |=> (ptrs[$past(ptr_sel_i)] == $past(ea_o)));

    // R5: post-increment stores the used address plus one
    p_postinc_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o && mode_i == AM_POSTINC) |=> (ptrs[$past(ptr_sel_i)] == $past(ea_o) + 16'd1));

    // R8: short I/O always lands in the standard I/O window
    p_shortio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == AM_SHORTIO) |-> (sel_io_o && !sel_xio_o));

    // R10: no access and no load means pointers hold
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en_i && !ld_en_i) |=> $stable(ptrs));
endmodule

// File: tb/sim_dsag_top.sv
module sim_dsag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [1:0]  ptr_sel_i = 2'd0;
    logic [5:0]  disp_i = 6'd0;
    logic [15:0] dir_addr_i = 16'd0;
    logic        ld_en_i = 1'b0;
    logic [1:0]  ld_sel_i = 2'd0;
    logic [15:0] ld_val_i = 16'd0;
    logic [15:0] ea_o, offset_o, wb_val_o, ptr_x_o, ptr_y_o, ptr_z_o;
    logic        sel_reg_o, sel_io_o, sel_xio_o, sel_sram_o, oor_o, illegal_o, wb_en_o;
    logic [1:0]  wb_sel_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dsag_top u0 (.*);

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", what, got, exp);
        end
    endtask

    task automatic drive(input logic en, input logic [2:0] m, input logic [1:0] s,
                         input logic [5:0] d, input logic [15:0] a);
        @(negedge clk);
        acc_en_i = en; mode_i = m; ptr_sel_i = s; disp_i = d; dir_addr_i = a;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_en_i = 0; mode_i = 3'd0; ld_en_i = 0; dir_addr_i = 16'd0;
    endtask

    task automatic load(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        ld_en_i = 1; ld_sel_i = s; ld_val_i = v;
        @(negedge clk);
        ld_en_i = 0;
    endtask

    // expected region code: 1 reg, 2 io, 3 xio, 4 sram, 0 none/oor
    task automatic chk_region(input string tag, input logic [15:0] a, input int reg_c,
                              input logic [15:0] off);
        chk({tag, " ea"}, ea_o, a);
        chk({tag, " sel"}, {sel_reg_o, sel_io_o, sel_xio_o, sel_sram_o},
            reg_c == 1 ? 4'b1000 : reg_c == 2 ? 4'b0100 : reg_c == 3 ? 4'b0010 :
            reg_c == 4 ? 4'b0001 : 4'b0000);
        chk({tag, " off"}, offset_o, off);
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk("R9 reset X", ptr_x_o, 0);
        chk("R9 reset Y", ptr_y_o, 0);
        chk("R9 reset Z", ptr_z_o, 0);
        chk("R10 reset wb", wb_en_o, 0);
    endtask

    task automatic t_direct();
        drive(1, 3'd0, 2'd0, 6'd0, 16'h0045);
        chk_region("R1 direct io", 16'h0045, 2, 16'h0025);
        chk("R1 no wb", wb_en_o, 0);
        drive(1, 3'd0, 2'd0, 6'd0, 16'hFFFF);
        chk("R1 full range oor", oor_o, 1);
        @(posedge clk); #1;
        chk("R1 X unchanged", ptr_x_o, 16'h1234);
        idle();
    endtask

    task automatic t_indirect();
        drive(1, 3'd1, 2'd0, 6'd0, 16'h0);
        chk("R2 ind X", ea_o, 16'h1234);
        drive(1, 3'd1, 2'd1, 6'd0, 16'h0);
        chk_region("R2 ind Y", 16'h0100, 4, 16'h0000);
        drive(1, 3'd1, 2'd2, 6'd0, 16'h0);
        chk("R2 ind Z", ea_o, 16'hFFFF);
        drive(1, 3'd1, 2'd3, 6'd0, 16'h0);
        chk("R2 sel3 illegal", illegal_o, 1);
        idle();
    endtask

    task automatic t_disp();
        drive(1, 3'd2, 2'd1, 6'd63, 16'h0);
        chk_region("R3 disp Y+63", 16'h013F, 4, 16'h003F);
        drive(1, 3'd2, 2'd2, 6'd1, 16'h0);
        chk("R3 disp Z wrap", ea_o, 16'h0000);
        chk("R3 disp Z illegal", illegal_o, 0);
        drive(1, 3'd2, 2'd0, 6'd5, 16'h0);
        chk("R3 disp X illegal", illegal_o, 1);
        chk("R3 disp X sel", {sel_reg_o, sel_io_o, sel_xio_o, sel_sram_o, oor_o}, 0);
        chk("R3 disp X wb", wb_en_o, 0);
        idle();
    endtask

    task automatic t_predec();
        drive(1, 3'd3, 2'd0, 6'd0, 16'h0);
        chk("R4 predec ea", ea_o, 16'h1233);
        chk("R4 predec wb", wb_en_o, 1);
        @(posedge clk); #1;
        chk("R4 predec X", ptr_x_o, 16'h1233);
        idle();
        load(2'd1, 16'h0000);
        drive(1, 3'd3, 2'd1, 6'd0, 16'h0);
        chk("R4 predec wrap ea", ea_o, 16'hFFFF);
        @(posedge clk); #1;
        chk("R4 predec wrap Y", ptr_y_o, 16'hFFFF);
        idle();
    endtask

    task automatic t_postinc();
        drive(1, 3'd4, 2'd2, 6'd0, 16'h0);
        chk("R5 postinc ea", ea_o, 16'hFFFF);
        @(posedge clk); #1;
        chk("R5 postinc wrap Z", ptr_z_o, 16'h0000);
        idle();
        drive(1, 3'd4, 2'd2, 6'd0, 16'h0);
        chk_region("R5 postinc reg", 16'h0000, 1, 16'h0000);
        @(posedge clk); #1;
        chk("R5 postinc Z", ptr_z_o, 16'h0001);
        idle();
    endtask

    task automatic t_gate();
        drive(0, 3'd4, 2'd2, 6'd0, 16'h0);
        chk("R10 gate ea", ea_o, 16'h0001);
        chk("R10 gate wb", wb_en_o, 0);
        @(posedge clk); #1;
        chk("R10 gate Z held", ptr_z_o, 16'h0001);
        drive(1, 3'd6, 2'd0, 6'd0, 16'h0);
        chk("R10 mode6 illegal", illegal_o, 1);
        idle();
    endtask

    task automatic t_prio();
        @(negedge clk);
        acc_en_i = 1; mode_i = 3'd4; ptr_sel_i = 2'd0;
        ld_en_i = 1; ld_sel_i = 2'd0; ld_val_i = 16'hAAAA;
        @(posedge clk); #1;
        chk("R9 wb beats load", ptr_x_o, 16'h1234);
        idle();
        load(2'd0, 16'h5555);
        @(posedge clk); #1;
        chk("R9 load X", ptr_x_o, 16'h5555);
    endtask

    task automatic t_regions();
        logic [15:0] addr [9] = '{16'h001F, 16'h0020, 16'h005F, 16'h0060, 16'h00FF,
                                  16'h0100, 16'h08FF, 16'h0900, 16'h0000};
        int          rc   [9] = '{1, 2, 2, 3, 3, 4, 4, 0, 1};
        logic [15:0] off  [9] = '{16'h1F, 16'h0, 16'h3F, 16'h0, 16'h9F,
                                  16'h0, 16'h7FF, 16'h0, 16'h0};
        for (int i = 0; i < 9; i++) begin
            drive(0, 3'd0, 2'd0, 6'd0, addr[i]);
            chk_region(i < 5 ? "R6 edge" : "R7 edge", addr[i], rc[i], off[i]);
        end
        drive(0, 3'd0, 2'd0, 6'd0, 16'h0900);
        chk("R7 oor flag", oor_o, 1);
        drive(0, 3'd0, 2'd0, 6'd0, 16'h08FF);
        chk("R7 top in range", oor_o, 0);
        idle();
    endtask

    task automatic t_shortio();
        drive(1, 3'd5, 2'd0, 6'd0, 16'h003F);
        chk_region("R8 short 3F", 16'h005F, 2, 16'h003F);
        drive(1, 3'd5, 2'd0, 6'd0, 16'hFFC0);
        chk_region("R8 short upper ignored", 16'h0020, 2, 16'h0000);
        chk("R8 no xio", sel_xio_o, 0);
        idle();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        load(2'd0, 16'h1234);
        load(2'd1, 16'h0100);
        load(2'd2, 16'hFFFF);
        t_direct();
        t_indirect();
        t_disp();
        t_predec();
        t_postinc();
        t_gate();
        t_prio();
        t_regions();
        t_shortio();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule